// File: doc/BRIEF.md
# Address Translation Request Sequencer

This block sits at the front of a memory management unit. It takes one memory access request at a time (virtual address, access kind, a handful of request flags and an alignment mask) together with the current system-control settings, and settles what the access turns into. Some requests finish at once: an exclusive-monitor clear, a misaligned data access, or any access made while translation is switched off. The rest query an external translation cache. A miss on a speculative prefetch is turned into an abort. Any other miss hands the address and context ID to an external table walker, waits for it, and queries the cache a second time.

The result is a one-cycle response carrying a physical address, an uncacheable flag, a fault code and a flag saying that the access-permission check still has to be run on the translated entry. The permission check itself, the translation cache storage and the walker all live outside this block.

Top module: `xlat_req_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle; `req_valid` is ignored while `req_ready` is low; each accepted request gives exactly one `rsp_valid` pulse, one cycle wide.
- R2: A request with `req_clrex` set completes with `rsp_pa` = 0, `rsp_uncache` = 1, `rsp_fault` = 0 and `rsp_perm` = 0, ahead of every other check and without a cache query.
- R3: Access kind encoding is 0 read, 1 write, 2 fetch (3 acts as a read). A fetch with `ctl_icache_en` low, or a read or write with `ctl_dcache_en` low, returns `rsp_uncache` = 1 on every result that carries no fault.
- R4: A read or write faults with code 1 (alignment) when (`ctl_strict_align` is set or `req_unal_ok` is clear) and the low address bits ANDed with `req_amask` are nonzero. A fetch never raises this fault.
- R5: With `ctl_mmu_en` low, `rsp_pa` equals the virtual address and `rsp_perm` = 0. The access is uncacheable when `ctl_remap_en` is low, or when `remap_norm_in0` or `remap_norm_out0` is 0, or when `remap_type0` is not 2.
- R6: With translation on, a cache hit returns the address given on `tlb_pa`, fault code 0 and `rsp_perm` = 1.
- R7: A hit whose entry has `tlb_nc` set returns `rsp_uncache` = 1.
- R8: A miss on a request with `req_pf` set returns fault code 2 and never raises `walk_req`.
- R9: Any other miss raises `walk_req` with `walk_va` and `walk_cid` equal to the request's address and context ID, holds it until `walk_done`, and then queries again. A walk that ends with `walk_fault` returns fault code 3.
- R10: If the second query after a clean walk still misses, the response carries fault code 4 (internal error).
- R11: Results that need no cache query appear one cycle after the accepting clock edge. A result decided by the first query appears two cycles after it.
- R12: While `rst` is high, and right after it, `req_ready` = 1 and `rsp_valid`, `tlb_lkup_valid` and `walk_req` are 0.
- R13: Every faulting response carries `rsp_pa` = 0, `rsp_uncache` = 0 and `rsp_perm` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New request offered |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle |
| req_va | input | VA_W | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_pf | input | 1 | Speculative prefetch, no fill on miss |
| req_clrex | input | 1 | Exclusive-monitor clear |
| req_unal_ok | input | 1 | Request tolerates unaligned addresses |
| req_amask | input | MASK_W | Alignment mask applied to low address bits |
| req_cid | input | CID_W | Context ID |
| ctl_mmu_en | input | 1 | Translation enable |
| ctl_strict_align | input | 1 | Strict alignment checking |
| ctl_icache_en | input | 1 | Instruction cache enable |
| ctl_dcache_en | input | 1 | Data cache enable |
| ctl_remap_en | input | 1 | Memory-type remap enable |
| remap_type0 | input | 2 | Primary remap type for region 0 |
| remap_norm_in0 | input | 1 | Inner normal-memory attribute bit 0 |
| remap_norm_out0 | input | 1 | Outer normal-memory attribute bit 0 |
| tlb_lkup_valid | output | 1 | Translation cache query active |
| tlb_lkup_va | output | VA_W | Query address |
| tlb_lkup_cid | output | CID_W | Query context ID |
| tlb_hit | input | 1 | Query hit, same cycle |
| tlb_pa | input | PA_W | Translated physical address for the query |
| tlb_nc | input | 1 | Hit entry is non-cacheable |
| walk_req | output | 1 | Table walk requested, level held |
| walk_va | output | VA_W | Address to walk |
| walk_cid | output | CID_W | Context ID for the walk |
| walk_done | input | 1 | Walk finished, one-cycle pulse |
| walk_fault | input | 1 | Walk ended in a fault, valid with walk_done |
| rsp_valid | output | 1 | Response pulse |
| rsp_pa | output | PA_W | Physical address |
| rsp_uncache | output | 1 | Access is uncacheable |
| rsp_fault | output | 3 | 0 none, 1 alignment, 2 prefetch miss, 3 walk, 4 internal |
| rsp_perm | output | 1 | Permission check still required |

## Verification
The assertions take for granted that the translation cache answers a query combinationally in the same cycle, that `walk_done` arrives only while `walk_req` is high and lasts one cycle, and that `walk_fault` is meaningful only alongside it. The bench's cache model responds purely from the current query address and context ID, and its walker model raises `walk_done` for a single cycle a few cycles after it sees `walk_req`, so the stimulus never leaves those bounds. Requests are only offered in the idle state except in the one test that offers a request while busy on purpose to show that it is dropped.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } xlat_kind_e;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_ALIGN    = 3'd1,
    FLT_PFMISS   = 3'd2,
    FLT_WALK     = 3'd3,
    FLT_INTERNAL = 3'd4
  } xlat_fault_e;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_LOOKUP    = 3'd1,
    ST_WALK_WAIT = 3'd2,
    ST_RELOOKUP  = 3'd3,
    ST_DONE      = 3'd4
  } xlat_state_e;

  // Remap type code meaning "normal memory" for region 0
  localparam logic [1:0] REMAP_NORMAL = 2'd2;

endpackage

// File: rtl/xlat_precheck.sv
module xlat_precheck
  import xlat_pkg::*;
#(
  parameter int MASK_W = 4
) (
  input  logic [1:0]        kind,
  input  logic              unal_ok,
  input  logic              strict,
  input  logic              ic_en,
  input  logic              dc_en,
  input  logic [MASK_W-1:0] amask,
  input  logic [MASK_W-1:0] va_lo,
  output logic              align_flt,
  output logic              base_unc
);

  logic is_fetch;
  logic must_align;

  always_comb begin
    is_fetch   = (kind == KIND_FETCH);
    must_align = strict || !unal_ok;
    align_flt  = !is_fetch && must_align && (|(va_lo & amask));
    base_unc   = is_fetch ? !ic_en : !dc_en;
  end

endmodule

// File: rtl/xlat_ident_attr.sv
module xlat_ident_attr
  import xlat_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input  logic [VA_W-1:0] va,
  input  logic            remap_en,
  input  logic [1:0]      type0,
  input  logic            norm_in0,
  input  logic            norm_out0,
  output logic [PA_W-1:0] ident_pa,
  output logic            ident_unc
);

  localparam int COMMON_W = (VA_W < PA_W) ? VA_W : PA_W;

  generate
    if (PA_W > VA_W) begin : g_widen
      assign ident_pa = {{(PA_W-VA_W){1'b0}}, va};
    end else begin : g_narrow
      assign ident_pa = va[COMMON_W-1:0];
    end
  endgenerate

  always_comb begin
    if (!remap_en) begin
      ident_unc = 1'b1;
    end else begin
      ident_unc = !norm_in0 || !norm_out0 || (type0 != REMAP_NORMAL);
    end
  end

endmodule

// File: rtl/xlat_seq_fsm.sv
module xlat_seq_fsm
  import xlat_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int CID_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic [CID_W-1:0] req_cid,
  input  logic             req_pf,
  input  logic             req_clrex,
  input  logic             mmu_en,
  input  logic             align_flt,
  input  logic             base_unc,
  input  logic             ident_unc,
  input  logic [PA_W-1:0]  ident_pa,
  output logic             req_ready,
  output logic             tlb_lkup_valid,
  output logic [VA_W-1:0]  tlb_lkup_va,
  output logic [CID_W-1:0] tlb_lkup_cid,
  input  logic             tlb_hit,
  input  logic [PA_W-1:0]  tlb_pa,
  input  logic             tlb_nc,
  output logic             walk_req,
  output logic [VA_W-1:0]  walk_va,
  output logic [CID_W-1:0] walk_cid,
  input  logic             walk_done,
  input  logic             walk_fault,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_uncache,
  output logic [2:0]       rsp_fault,
  output logic             rsp_perm
);

  xlat_state_e      state_q;
  logic [VA_W-1:0]  va_q;
  logic [CID_W-1:0] cid_q;
  logic             pf_q;
  logic             base_unc_q;
  logic             walk_req_q;
  logic             rsp_valid_q;
  logic [PA_W-1:0]  rsp_pa_q;
  logic             rsp_unc_q;
  xlat_fault_e      rsp_fault_q;
  logic             rsp_perm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      cid_q       <= '0;
      pf_q        <= 1'b0;
      base_unc_q  <= 1'b0;
      walk_req_q  <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_pa_q    <= '0;
      rsp_unc_q   <= 1'b0;
      rsp_fault_q <= FLT_NONE;
      rsp_perm_q  <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q       <= req_va;
            cid_q      <= req_cid;
            pf_q       <= req_pf;
            base_unc_q <= base_unc;
            if (req_clrex) begin
              state_q     <= ST_DONE;
              rsp_valid_q <= 1'b1;
              rsp_pa_q    <= '0;
              rsp_unc_q   <= 1'b1;
              rsp_fault_q <= FLT_NONE;
              rsp_perm_q  <= 1'b0;
            end else if (align_flt) begin
              state_q     <= ST_DONE;
              rsp_valid_q <= 1'b1;
              rsp_pa_q    <= '0;
              rsp_unc_q   <= 1'b0;
              rsp_fault_q <= FLT_ALIGN;
              rsp_perm_q  <= 1'b0;
            end else if (!mmu_en) begin
              state_q     <= ST_DONE;
              rsp_valid_q <= 1'b1;
              rsp_pa_q    <= ident_pa;
              rsp_unc_q   <= base_unc || ident_unc;
              rsp_fault_q <= FLT_NONE;
              rsp_perm_q  <= 1'b0;
            end else begin
              state_q <= ST_LOOKUP;
            end
          end
        end
        ST_LOOKUP: begin
          if (tlb_hit) begin
            state_q     <= ST_DONE;
            rsp_valid_q <= 1'b1;
            rsp_pa_q    <= tlb_pa;
            rsp_unc_q   <= base_unc_q || tlb_nc;
            rsp_fault_q <= FLT_NONE;
            rsp_perm_q  <= 1'b1;
          end else if (pf_q) begin
            state_q     <= ST_DONE;
            rsp_valid_q <= 1'b1;
            rsp_pa_q    <= '0;
            rsp_unc_q   <= 1'b0;
            rsp_fault_q <= FLT_PFMISS;
            rsp_perm_q  <= 1'b0;
          end else begin
            state_q    <= ST_WALK_WAIT;
            walk_req_q <= 1'b1;
          end
        end
        ST_WALK_WAIT: begin
          if (walk_done) begin
            walk_req_q <= 1'b0;
            if (walk_fault) begin
              state_q     <= ST_DONE;
              rsp_valid_q <= 1'b1;
              rsp_pa_q    <= '0;
              rsp_unc_q   <= 1'b0;
              rsp_fault_q <= FLT_WALK;
              rsp_perm_q  <= 1'b0;
            end else begin
              state_q <= ST_RELOOKUP;
            end
          end
        end
        ST_RELOOKUP: begin
          state_q     <= ST_DONE;
          rsp_valid_q <= 1'b1;
          if (tlb_hit) begin
            rsp_pa_q    <= tlb_pa;
            rsp_unc_q   <= base_unc_q || tlb_nc;
            rsp_fault_q <= FLT_NONE;
            rsp_perm_q  <= 1'b1;
          end else begin
            rsp_pa_q    <= '0;
            rsp_unc_q   <= 1'b0;
            rsp_fault_q <= FLT_INTERNAL;
            rsp_perm_q  <= 1'b0;
          end
        end
        ST_DONE: begin
          state_q <= ST_IDLE;
        end
        default: begin
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign req_ready      = (state_q == ST_IDLE);
  assign tlb_lkup_valid = (state_q == ST_LOOKUP) || (state_q == ST_RELOOKUP);
  assign tlb_lkup_va    = va_q;
  assign tlb_lkup_cid   = cid_q;
  assign walk_req       = walk_req_q;
  assign walk_va        = va_q;
  assign walk_cid       = cid_q;
  assign rsp_valid      = rsp_valid_q;
  assign rsp_pa         = rsp_pa_q;
  assign rsp_uncache    = rsp_unc_q;
  assign rsp_fault      = rsp_fault_q;
  assign rsp_perm       = rsp_perm_q;

endmodule

// File: rtl/xlat_req_seq.sv
module xlat_req_seq
  import xlat_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int CID_W  = 8,
  parameter int MASK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [1:0]        req_kind,
  input  logic              req_pf,
  input  logic              req_clrex,
  input  logic              req_unal_ok,
  input  logic [MASK_W-1:0] req_amask,
  input  logic [CID_W-1:0]  req_cid,
  input  logic              ctl_mmu_en,
  input  logic              ctl_strict_align,
  input  logic              ctl_icache_en,
  input  logic              ctl_dcache_en,
  input  logic              ctl_remap_en,
  input  logic [1:0]        remap_type0,
  input  logic              remap_norm_in0,
  input  logic              remap_norm_out0,
  output logic              tlb_lkup_valid,
  output logic [VA_W-1:0]   tlb_lkup_va,
  output logic [CID_W-1:0]  tlb_lkup_cid,
  input  logic              tlb_hit,
  input  logic [PA_W-1:0]   tlb_pa,
  input  logic              tlb_nc,
  output logic              walk_req,
  output logic [VA_W-1:0]   walk_va,
  output logic [CID_W-1:0]  walk_cid,
  input  logic              walk_done,
  input  logic              walk_fault,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_uncache,
  output logic [2:0]        rsp_fault,
  output logic              rsp_perm
);

  logic            align_flt;
  logic            base_unc;
  logic            ident_unc;
  logic [PA_W-1:0] ident_pa;

  xlat_precheck #(.MASK_W(MASK_W)) u_pre (
    .kind      (req_kind),
    .unal_ok   (req_unal_ok),
    .strict    (ctl_strict_align),
    .ic_en     (ctl_icache_en),
    .dc_en     (ctl_dcache_en),
    .amask     (req_amask),
    .va_lo     (req_va[MASK_W-1:0]),
    .align_flt (align_flt),
    .base_unc  (base_unc)
  );

  xlat_ident_attr #(.VA_W(VA_W), .PA_W(PA_W)) u_ident (
    .va        (req_va),
    .remap_en  (ctl_remap_en),
    .type0     (remap_type0),
    .norm_in0  (remap_norm_in0),
    .norm_out0 (remap_norm_out0),
    .ident_pa  (ident_pa),
    .ident_unc (ident_unc)
  );

  xlat_seq_fsm #(.VA_W(VA_W), .PA_W(PA_W), .CID_W(CID_W)) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_va         (req_va),
    .req_cid        (req_cid),
    .req_pf         (req_pf),
    .req_clrex      (req_clrex),
    .mmu_en         (ctl_mmu_en),
    .align_flt      (align_flt),
    .base_unc       (base_unc),
    .ident_unc      (ident_unc),
    .ident_pa       (ident_pa),
    .req_ready      (req_ready),
    .tlb_lkup_valid (tlb_lkup_valid),
    .tlb_lkup_va    (tlb_lkup_va),
    .tlb_lkup_cid   (tlb_lkup_cid),
    .tlb_hit        (tlb_hit),
    .tlb_pa         (tlb_pa),
    .tlb_nc         (tlb_nc),
    .walk_req       (walk_req),
    .walk_va        (walk_va),
    .walk_cid       (walk_cid),
    .walk_done      (walk_done),
    .walk_fault     (walk_fault),
    .rsp_valid      (rsp_valid),
    .rsp_pa         (rsp_pa),
    .rsp_uncache    (rsp_uncache),
    .rsp_fault      (rsp_fault),
    .rsp_perm       (rsp_perm)
  );

endmodule

// File: rtl/xlat_req_seq_chk.sv
module xlat_req_seq_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_clrex,
  input logic            tlb_lkup_valid,
  input logic            tlb_hit,
  input logic            walk_req,
  input logic            walk_done,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_pa,
  input logic            rsp_uncache,
  input logic [2:0]      rsp_fault,
  input logic            rsp_perm
);

  // R1: the response is a single-cycle pulse and never overlaps idle
  p_rsp_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_rsp_not_idle_r1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  // R2 / R11: exclusive clear answers next cycle with address 0, uncacheable
  p_clrex_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_clrex) |=>
      (rsp_valid && rsp_pa == '0 && rsp_uncache && rsp_fault == 3'd0 && !rsp_perm));

  // R6: a first-query hit answers with permission check pending
  p_hit_perm_r6: assert property (@(posedge clk) disable iff (rst)
    (tlb_lkup_valid && tlb_hit) |=> (rsp_valid && rsp_perm && rsp_fault == 3'd0));

  // R9: a walk is only requested right after a missing query
  p_walk_after_miss_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(walk_req) |-> $past(tlb_lkup_valid && !tlb_hit));

  // R9: walk request held until the walker reports completion
  p_walk_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (walk_req && !walk_done) |=> walk_req);

  // R10: internal error only follows a missing query
  p_internal_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == 3'd4) |-> $past(tlb_lkup_valid && !tlb_hit));

  // R13: faulting responses carry no address, attribute or permission flag
  p_fault_clean_r13: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 3'd0) |-> (rsp_pa == '0 && !rsp_uncache && !rsp_perm));

endmodule

bind xlat_req_seq xlat_req_seq_chk #(.PA_W(PA_W)) u_chk (.*);

// File: tb/sim_xlat_req_seq.sv
`timescale 1ns/1ps
module sim_xlat_req_seq;

  localparam int VA_W = 32, PA_W = 32, CID_W = 8, MASK_W = 4;
  localparam logic [CID_W-1:0] CID = 8'h5A;

  typedef struct packed {
    logic [1:0]  kind;
    logic        pf, clrex, unal;
    logic [3:0]  amask;
    logic [31:0] va;
    logic        mmu, strict, ic, dc, trem;
    logic [1:0]  t0;
    logic        nin, nout;
    logic [1:0]  wmode;   // 0 walk fills, 1 walk faults, 2 walk fills nothing
    logic [2:0]  efault;
    logic [31:0] epa;
    logic        eunc, eperm, ewalk;
    logic [2:0]  elat;    // 0 = latency not checked
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    // kind pf cx un am    va            mm st ic dc tr t0 ni no wm  ef   epa           eu ep ew lat rq
    '{2'd0,1'b0,1'b1,1'b0,4'h3,32'h1234_5679,1'b1,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,2'd0,3'd0,32'h0,       1'b1,1'b0,1'b0,3'd1,4'd2},  // R2
    '{2'd1,1'b0,1'b1,1'b0,4'h3,32'h0000_0102,1'b0,1'b1,1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,2'd0,3'd0,32'h0,       1'b1,1'b0,1'b0,3'd1,4'd2},  // R2 priority
    '{2'd0,1'b0,1'b0,1'b0,4'h3,32'h0000_4100,1'b0,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,2'd0,3'd0,32'h0000_4100,1'b1,1'b0,1'b0,3'd1,4'd5},  // R5 remap off
    '{2'd1,1'b0,1'b0,1'b0,4'h3,32'h0000_0102,1'b0,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,2'd0,3'd1,32'h0,       1'b0,1'b0,1'b0,3'd1,4'd4},  // R4
    '{2'd1,1'b0,1'b0,1'b1,4'h3,32'h0000_0102,1'b0,1'b1,1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,2'd0,3'd1,32'h0,       1'b0,1'b0,1'b0,3'd1,4'd4},  // R4 strict
    '{2'd1,1'b0,1'b0,1'b1,4'h3,32'h0000_0102,1'b0,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,2'd0,3'd0,32'h0000_0102,1'b1,1'b0,1'b0,3'd1,4'd4},  // R4 allowed
    '{2'd2,1'b0,1'b0,1'b0,4'h3,32'h0000_0102,1'b0,1'b1,1'b1,1'b1,1'b1,2'd2,1'b1,1'b1,2'd0,3'd0,32'h0000_0102,1'b0,1'b0,1'b0,3'd1,4'd4},  // R4 fetch
    '{2'd0,1'b0,1'b0,1'b0,4'h3,32'h0000_8000,1'b0,1'b0,1'b1,1'b1,1'b1,2'd2,1'b0,1'b1,2'd0,3'd0,32'h0000_8000,1'b1,1'b0,1'b0,3'd1,4'd5},  // R5 inner
    '{2'd0,1'b0,1'b0,1'b0,4'h3,32'h0000_8000,1'b0,1'b0,1'b1,1'b1,1'b1,2'd1,1'b1,1'b1,2'd0,3'd0,32'h0000_8000,1'b1,1'b0,1'b0,3'd1,4'd5},  // R5 type
    '{2'd0,1'b0,1'b0,1'b0,4'h3,32'h0000_8000,1'b0,1'b0,1'b1,1'b1,1'b1,2'd2,1'b1,1'b0,2'd0,3'd0,32'h0000_8000,1'b1,1'b0,1'b0,3'd1,4'd5},  // R5 outer
    '{2'd0,1'b0,1'b0,1'b0,4'h3,32'h0000_8004,1'b0,1'b0,1'b1,1'b1,1'b1,2'd2,1'b1,1'b1,2'd0,3'd0,32'h0000_8004,1'b0,1'b0,1'b0,3'd1,4'd5},  // R5 cacheable
    '{2'd2,1'b0,1'b0,1'b0,4'h3,32'h0000_8000,1'b0,1'b0,1'b0,1'b1,1'b1,2'd2,1'b1,1'b1,2'd0,3'd0,32'h0000_8000,1'b1,1'b0,1'b0,3'd1,4'd3},  // R3 icache off
    '{2'd0,1'b0,1'b0,1'b0,4'h3,32'h0000_8000,1'b0,1'b0,1'b1,1'b0,1'b1,2'd2,1'b1,1'b1,2'd0,3'd0,32'h0000_8000,1'b1,1'b0,1'b0,3'd1,4'd3},  // R3 dcache off
    '{2'd0,1'b0,1'b0,1'b0,4'h3,32'h0000_8000,1'b0,1'b0,1'b0,1'b1,1'b1,2'd2,1'b1,1'b1,2'd0,3'd0,32'h0000_8000,1'b0,1'b0,1'b0,3'd1,4'd3},  // R3 icache irrelevant
    '{2'd0,1'b0,1'b0,1'b0,4'h3,32'h0001_0abc,1'b1,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,2'd0,3'd0,32'h8002_0abc,1'b0,1'b1,1'b0,3'd2,4'd6},  // R6
    '{2'd0,1'b0,1'b0,1'b0,4'h3,32'h0001_1abc,1'b1,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,2'd0,3'd0,32'h8002_1abc,1'b1,1'b1,1'b0,3'd2,4'd7},  // R7
    '{2'd1,1'b0,1'b0,1'b0,4'h3,32'h0001_0abc,1'b1,1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,2'd0,3'd0,32'h8002_0abc,1'b1,1'b1,1'b0,3'd2,4'd3},  // R3 hit
    '{2'd0,1'b1,1'b0,1'b0,4'h3,32'h0003_0040,1'b1,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,2'd0,3'd2,32'h0,       1'b0,1'b0,1'b0,3'd2,4'd8},  // R8
    '{2'd0,1'b1,1'b0,1'b0,4'h3,32'h0001_0004,1'b1,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,2'd0,3'd0,32'h8002_0004,1'b0,1'b1,1'b0,3'd2,4'd6},  // R6 prefetch hit
    '{2'd0,1'b0,1'b0,1'b0,4'h3,32'h0003_0040,1'b1,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,2'd0,3'd0,32'h9003_0040,1'b0,1'b1,1'b1,3'd0,4'd9},  // R9 fill
    '{2'd1,1'b0,1'b0,1'b0,4'h3,32'h0003_0040,1'b1,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,2'd1,3'd3,32'h0,       1'b0,1'b0,1'b1,3'd0,4'd9},  // R9 fault
    '{2'd0,1'b0,1'b0,1'b0,4'h3,32'h0003_0040,1'b1,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,2'd2,3'd4,32'h0,       1'b0,1'b0,1'b1,3'd0,4'd10}, // R10
    '{2'd0,1'b0,1'b0,1'b0,4'h1,32'h0001_0001,1'b1,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,2'd0,3'd1,32'h0,       1'b0,1'b0,1'b0,3'd1,4'd11}  // R11 / R4 no query
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [VA_W-1:0]   req_va = '0;
  logic [1:0]        req_kind = '0;
  logic              req_pf = 1'b0, req_clrex = 1'b0, req_unal_ok = 1'b0;
  logic [MASK_W-1:0] req_amask = '0;
  logic [CID_W-1:0]  req_cid = CID;
  logic ctl_mmu_en = 1'b0, ctl_strict_align = 1'b0, ctl_icache_en = 1'b0;
  logic ctl_dcache_en = 1'b0, ctl_remap_en = 1'b0;
  logic [1:0] remap_type0 = '0;
  logic remap_norm_in0 = 1'b0, remap_norm_out0 = 1'b0;
  logic              tlb_lkup_valid;
  logic [VA_W-1:0]   tlb_lkup_va;
  logic [CID_W-1:0]  tlb_lkup_cid;
  logic              tlb_hit;
  logic [PA_W-1:0]   tlb_pa;
  logic              tlb_nc;
  logic              walk_req;
  logic [VA_W-1:0]   walk_va;
  logic [CID_W-1:0]  walk_cid;
  logic              walk_done = 1'b0, walk_fault = 1'b0;
  logic              rsp_valid;
  logic [PA_W-1:0]   rsp_pa;
  logic              rsp_uncache;
  logic [2:0]        rsp_fault;
  logic              rsp_perm;

  xlat_req_seq #(.VA_W(VA_W), .PA_W(PA_W), .CID_W(CID_W), .MASK_W(MASK_W)) u0 (.*);

  int tests = 0, fails = 0;
  int cur_row = -1, dyn_row = -2;
  logic [1:0] cur_wmode = 2'd0;
  int walk_rises = 0;
  logic walk_prev = 1'b0;
  logic [VA_W-1:0] seen_wva = '0;
  logic [CID_W-1:0] seen_wcid = '0;
  int wcnt = 0;
  int cyc = 0;

  // Translation cache model: fixed pages plus one page the walker may fill
  always_comb begin
    tlb_hit = 1'b0;
    tlb_pa  = '0;
    tlb_nc  = 1'b0;
    if (tlb_lkup_valid && tlb_lkup_cid == CID) begin
      if (tlb_lkup_va[31:12] == 20'h00010) begin
        tlb_hit = 1'b1; tlb_pa = {20'h80020, tlb_lkup_va[11:0]};
      end else if (tlb_lkup_va[31:12] == 20'h00011) begin
        tlb_hit = 1'b1; tlb_pa = {20'h80021, tlb_lkup_va[11:0]}; tlb_nc = 1'b1;
      end else if (tlb_lkup_va[31:12] == 20'h00030 && dyn_row == cur_row) begin
        tlb_hit = 1'b1; tlb_pa = {20'h90030, tlb_lkup_va[11:0]};
      end
    end
  end

  // Walker model and walk monitor, driven away from the active edge
  always @(negedge clk) begin
    walk_done  <= 1'b0;
    walk_fault <= 1'b0;
    if (walk_req && !walk_prev) begin
      walk_rises++;
      seen_wva  = walk_va;
      seen_wcid = walk_cid;
    end
    walk_prev <= walk_req;
    if (walk_req && !walk_done) begin
      wcnt++;
      if (wcnt == 3) begin
        wcnt = 0;
        walk_done  <= 1'b1;
        walk_fault <= (cur_wmode == 2'd1);
        if (cur_wmode == 2'd0) dyn_row <= cur_row;
      end
    end else begin
      wcnt = 0;
    end
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    req_kind = v.kind; req_pf = v.pf; req_clrex = v.clrex; req_unal_ok = v.unal;
    req_amask = v.amask; req_va = v.va; req_cid = CID;
    ctl_mmu_en = v.mmu; ctl_strict_align = v.strict; ctl_icache_en = v.ic;
    ctl_dcache_en = v.dc; ctl_remap_en = v.trem; remap_type0 = v.t0;
    remap_norm_in0 = v.nin; remap_norm_out0 = v.nout;
  endtask

  task automatic run_row(input vec_t v, input int idx);
    int lat;
    int rises0;
    string tag;
    tag = $sformatf("row%0d R%0d", idx, v.rq);
    @(negedge clk);
    cur_row = idx;
    cur_wmode = v.wmode;
    rises0 = walk_rises;
    apply(v);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check(rsp_valid, {tag, " response seen"}, 32'(rsp_valid), 32'd1);
    check(rsp_fault == v.efault, {tag, " fault"}, 32'(rsp_fault), 32'(v.efault));
    check(rsp_pa == v.epa, {tag, " pa"}, rsp_pa, v.epa);
    check(rsp_uncache == v.eunc, {tag, " uncache"}, 32'(rsp_uncache), 32'(v.eunc));
    check(rsp_perm == v.eperm, {tag, " perm"}, 32'(rsp_perm), 32'(v.eperm));
    check((walk_rises - rises0) == int'(v.ewalk), {tag, " walk count R8/R9"},
          32'(walk_rises - rises0), 32'(v.ewalk));
    if (v.ewalk) begin
      check(seen_wva == v.va && seen_wcid == CID, {tag, " walk address R9"}, seen_wva, v.va);
    end
    if (v.elat != 3'd0) begin
      check(lat == int'(v.elat), {tag, " latency R11"}, 32'(lat), 32'(v.elat));
    end
    @(negedge clk);
    check(!rsp_valid && req_ready, {tag, " single pulse R1"}, 32'(rsp_valid), 32'd0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin : main
    int lat;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    check(req_ready && !rsp_valid && !tlb_lkup_valid && !walk_req, "R12 during reset",
          {28'd0, req_ready, rsp_valid, tlb_lkup_valid, walk_req}, 32'h8);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !rsp_valid && !tlb_lkup_valid && !walk_req, "R12 after reset",
          {28'd0, req_ready, rsp_valid, tlb_lkup_valid, walk_req}, 32'h8);

    for (int i = 0; i < NV; i++) run_row(VECS[i], i);

    // R1: request offered while busy on a walk is ignored
    @(negedge clk);
    cur_row = 100;
    cur_wmode = 2'd0;
    apply(VECS[19]);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // now busy: offer an exclusive clear, which would answer pa 0
    req_clrex = 1'b1;
    check(!req_ready, "R1 busy not ready", 32'(req_ready), 32'd0);
    lat = 0;
    while (!rsp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
    req_clrex = 1'b0;
    check(rsp_pa == 32'h9003_0040 && rsp_perm, "R1 busy request dropped", rsp_pa, 32'h9003_0040);
    @(negedge clk);
    repeat (4) begin
      check(!rsp_valid, "R1 no extra response", 32'(rsp_valid), 32'd0);
      @(negedge clk);
    end

    // R12: reset mid-walk returns to idle
    cur_row = 101;
    apply(VECS[19]);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !walk_req && !rsp_valid, "R12 reset mid-walk",
          {29'd0, req_ready, walk_req, rsp_valid}, 32'h4);
    repeat (6) @(negedge clk);
    check(!rsp_valid && req_ready, "R12 no stale response", 32'(rsp_valid), 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule